// File: doc/BRIEF.md
# IDE Register Window Unlock Sequencer

This block sits beside the command-block decode of a legacy IDE port and watches every host access. A fixed three-access knock swaps the task-file registers out of that address range and puts a small bank of chip control registers in their place. Once the window is open, software stages a read-cycle timing byte and a write-cycle timing byte for each of two drives, picks the drive with the low bit of a selector register, and places a shared address-setup value in that register's upper bits. It then writes a commit code to the control register. A relock code written to the key offset closes the window and gives the range back to the task file.

The committed timing bytes and the address-setup value leave the block as plain outputs for the drive timing logic. They change only on a commit, so a half-programmed set never reaches that logic. While the window is closed, `tf_sel` routes every access to the task file and the block never drives read data.

Top module: `ide_cfgwin`

## Requirements
- R1: After `rst_n` is held low at a clock edge, the window is closed (`window_open`=0, `tf_sel`=1). Every committed read and write timing byte is 0x59, the slowest value, and `setup_timing` is 0x30.
- R2: The window opens on the clock edge after this sequence with no other access in between: a 16-bit read (`io_wide`=1) of offset 1, another 16-bit read of offset 1, then an 8-bit write (`io_wide`=0) of 0x03 to offset 2.
- R3: Any access that does not match the next knock step sends the sequencer back to idle and leaves the window closed. Examples are a write between the two reads, an 8-bit read at offset 1, a third read, and a wrong value or a 16-bit width on the final write.
- R4: While the window is closed, `cfg_rvalid` stays 0, `tf_sel` stays 1, and writes to window offsets have no effect on any register or output.
- R5: While the window is open, `tf_sel` is 0 and a read drives `cfg_rvalid`=1 with combinational `cfg_rdata` as follows. Offset 0 gives the read timing staged for the selected drive. Offset 1 gives the staged write timing for that drive. Offset 3 gives the last control value, offset 5 the strap and offset 6 the selector. Offsets 2, 4 and 7 read 0x00.
- R6: Bit 0 of the selector register (offset 6) chooses the drive whose staged timing a write to offset 0 or offset 1 loads (0 = drive 0, 1 = drive 1).
- R7: Bit 0 of the strap register (offset 5) mirrors `bus_clk_25`: 0 means a 33 MHz bus clock and 1 means 25 MHz. Its other bits read 0, and writes to offset 5 are ignored.
- R8: A write of 0x85 to offset 3 while the window is open copies both staged sets into `rd_timing` and `wr_timing` on the next edge, with drive 0 in the low byte. It also copies the selector with bit 0 cleared into `setup_timing`. Any other control value commits nothing.
- R9: Staging writes and selector writes leave the timing outputs unchanged until a commit.
- R10: While the window is open, an 8-bit write of 0x83 to offset 2 closes it on the next edge. A 16-bit write, or any other value, leaves it open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 3 | Command-block offset of the access |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wide | input | 1 | Access width: 1 = 16-bit, 0 = 8-bit |
| io_wdata | input | 8 | Write data (low byte) |
| bus_clk_25 | input | 1 | Bus clock strap: 1 = 25 MHz, 0 = 33 MHz |
| cfg_rdata | output | 8 | Window read data |
| cfg_rvalid | output | 1 | Window is driving read data this cycle |
| tf_sel | output | 1 | Accesses go to the task file |
| window_open | output | 1 | Control window is unlocked |
| rd_timing | output | 16 | Committed read timing, drive 0 in bits 7:0 |
| wr_timing | output | 16 | Committed write timing, drive 0 in bits 7:0 |
| setup_timing | output | 8 | Committed shared address-setup value |

## Verification
A sequencer stuck in a middle knock state shows at the ports one edge after the next access. The key write then either fails to open the window or opens it without the reads that should come first, and `window_open` with `tf_sel` reveals this at once. A wrong drive select or a staging slot that takes the wrong write stays hidden at the outputs until the next commit. For that reason the bench also reads staged values back through the window, which exposes such a fault in the same cycle as the read. Early or spurious commits change `rd_timing`, `wr_timing` or `setup_timing` one edge after the offending write.

// File: rtl/ide_cfgwin_pkg.sv
// Shared definitions for the IDE control-window sequencer.
// Offsets and codes are fixed by the software sequence that drives the block.
package ide_cfgwin_pkg;

    typedef enum logic [1:0] {
        KN_IDLE = 2'd0,
        KN_ONE  = 2'd1,
        KN_TWO  = 2'd2,
        KN_OPEN = 2'd3
    } knock_e;

    localparam logic [2:0] OFS_RDTIM  = 3'd0;
    localparam logic [2:0] OFS_WRTIM  = 3'd1;
    localparam logic [2:0] OFS_KEY    = 3'd2;
    localparam logic [2:0] OFS_CTRL   = 3'd3;
    localparam logic [2:0] OFS_STRAP  = 3'd5;
    localparam logic [2:0] OFS_SEL    = 3'd6;
    localparam logic [2:0] OFS_KNOCK  = 3'd1;

    localparam logic [7:0] KEY_UNLOCK = 8'h03;
    localparam logic [7:0] KEY_RELOCK = 8'h83;
    localparam logic [7:0] KEY_COMMIT = 8'h85;

endpackage

// File: rtl/ide_knock_fsm.sv
// Knock detector and window state.
// Assumes io_rd and io_wr are one-cycle strobes and never both high.
// A non-matching access at any middle step returns to idle.
module ide_knock_fsm
    import ide_cfgwin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic          io_wide,
    input  logic [DW-1:0] io_wdata,
    output logic          open_o
);

    knock_e state_q, state_d;
    logic   any_acc;
    logic   knock_rd;
    logic   key_wr;

    // Classify the current access
    always_comb begin
        any_acc  = io_rd | io_wr;
        knock_rd = io_rd & io_wide & (io_addr == OFS_KNOCK);
        key_wr   = io_wr & ~io_wide & (io_addr == OFS_KEY);
    end

    // Next-state selection for the knock sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KN_IDLE: if (knock_rd) state_d = KN_ONE;
            KN_ONE:  if (knock_rd) state_d = KN_TWO;
                     else if (any_acc) state_d = KN_IDLE;
            KN_TWO:  if (key_wr && io_wdata[7:0] == KEY_UNLOCK) state_d = KN_OPEN;
                     else if (any_acc) state_d = KN_IDLE;
            KN_OPEN: if (key_wr && io_wdata[7:0] == KEY_RELOCK) state_d = KN_IDLE;
            default: state_d = KN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KN_IDLE;
        else        state_q <= state_d;
    end

    assign open_o = (state_q == KN_OPEN);

endmodule

// File: rtl/ide_cfg_regs.sv
// Window register bank: per-drive staging, selector and control.
// Writes land only while the window is open; reads are combinational.
// Produces a one-cycle commit pulse on the commit code.
module ide_cfg_regs
    import ide_cfgwin_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          NUM_DEV   = 2,
    parameter logic [7:0]  RST_TIM   = 8'h59,
    parameter logic [7:0]  RST_SEL   = 8'h30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  open_i,
    input  logic [2:0]            io_addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [DW-1:0]         io_wdata,
    input  logic                  strap_i,
    output logic [DW-1:0]         rdata_o,
    output logic                  rvalid_o,
    output logic [NUM_DEV*DW-1:0] rd_stage_o,
    output logic [NUM_DEV*DW-1:0] wr_stage_o,
    output logic [DW-1:0]         sel_o,
    output logic                  commit_o
);

    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [DW-1:0]    rd_stage [NUM_DEV];
    logic [DW-1:0]    wr_stage [NUM_DEV];
    logic [DW-1:0]    sel_q;
    logic [DW-1:0]    ctrl_q;
    logic [SEL_W-1:0] dev;
    logic             wr_en;

    assign dev   = sel_q[SEL_W-1:0];
    assign wr_en = open_i & io_wr;

    // Per-drive staging slots, loaded when the selector points at them
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_stage[g] <= RST_TIM;
                wr_stage[g] <= RST_TIM;
            end else if (wr_en && dev == SEL_W'(g)) begin
                if (io_addr == OFS_RDTIM) rd_stage[g] <= io_wdata;
                if (io_addr == OFS_WRTIM) wr_stage[g] <= io_wdata;
            end
        end
        assign rd_stage_o[g*DW +: DW] = rd_stage[g];
        assign wr_stage_o[g*DW +: DW] = wr_stage[g];
    end

    // Selector and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= RST_SEL;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (io_addr == OFS_SEL)  sel_q  <= io_wdata;
            if (io_addr == OFS_CTRL) ctrl_q <= io_wdata;
        end
    end

    // Commit strobe on the completion code
    assign commit_o = wr_en & (io_addr == OFS_CTRL) & (io_wdata[7:0] == KEY_COMMIT);

    // Read multiplexer for the open window
    always_comb begin
        rdata_o = '0;
        unique case (io_addr)
            OFS_RDTIM: rdata_o = rd_stage[dev];
            OFS_WRTIM: rdata_o = wr_stage[dev];
            OFS_CTRL:  rdata_o = ctrl_q;
            OFS_STRAP: rdata_o = {{(DW-1){1'b0}}, strap_i};
            OFS_SEL:   rdata_o = sel_q;
            default:   rdata_o = '0;
        endcase
    end

    assign rvalid_o = open_i & io_rd;
    assign sel_o    = sel_q;

endmodule

// File: rtl/ide_tim_commit.sv
// Committed timing registers fed to the drive timing logic.
// All drives and the setup value update together on the commit pulse.
module ide_tim_commit #(
    parameter int          DW      = 8,
    parameter int          NUM_DEV = 2,
    parameter logic [7:0]  RST_TIM = 8'h59,
    parameter logic [7:0]  RST_SETUP = 8'h30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_i,
    input  logic [NUM_DEV*DW-1:0] rd_stage_i,
    input  logic [NUM_DEV*DW-1:0] wr_stage_i,
    input  logic [DW-1:0]         sel_i,
    output logic [NUM_DEV*DW-1:0] rd_tim_o,
    output logic [NUM_DEV*DW-1:0] wr_tim_o,
    output logic [DW-1:0]         setup_o
);

    localparam int            SEL_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [DW-1:0] SETUP_MASK = ~DW'((1 << SEL_W) - 1);

    // Per-drive committed bytes
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_tim_o[g*DW +: DW] <= RST_TIM;
                wr_tim_o[g*DW +: DW] <= RST_TIM;
            end else if (commit_i) begin
                rd_tim_o[g*DW +: DW] <= rd_stage_i[g*DW +: DW];
                wr_tim_o[g*DW +: DW] <= wr_stage_i[g*DW +: DW];
            end
        end
    end

    // Shared setup value, drive-select bits stripped
    always_ff @(posedge clk) begin
        if (!rst_n)        setup_o <= RST_SETUP;
        else if (commit_i) setup_o <= sel_i & SETUP_MASK;
    end

endmodule

// File: rtl/ide_cfgwin.sv
// Top of the IDE control-window sequencer.
// Assumes one access per strobe cycle; tf_sel steers the task-file decode.
module ide_cfgwin #(
    parameter int          DW        = 8,
    parameter int          NUM_DEV   = 2,
    parameter logic [7:0]  RST_TIM   = 8'h59,
    parameter logic [7:0]  RST_SETUP = 8'h30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            io_addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic                  io_wide,
    input  logic [DW-1:0]         io_wdata,
    input  logic                  bus_clk_25,
    output logic [DW-1:0]         cfg_rdata,
    output logic                  cfg_rvalid,
    output logic                  tf_sel,
    output logic                  window_open,
    output logic [NUM_DEV*DW-1:0] rd_timing,
    output logic [NUM_DEV*DW-1:0] wr_timing,
    output logic [DW-1:0]         setup_timing
);

    logic                  open_w;
    logic                  commit_w;
    logic [NUM_DEV*DW-1:0] rd_stage_w;
    logic [NUM_DEV*DW-1:0] wr_stage_w;
    logic [DW-1:0]         sel_w;

    ide_knock_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wide  (io_wide),
        .io_wdata (io_wdata),
        .open_o   (open_w)
    );

    ide_cfg_regs #(
        .DW(DW), .NUM_DEV(NUM_DEV), .RST_TIM(RST_TIM), .RST_SEL(RST_SETUP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (open_w),
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .strap_i    (bus_clk_25),
        .rdata_o    (cfg_rdata),
        .rvalid_o   (cfg_rvalid),
        .rd_stage_o (rd_stage_w),
        .wr_stage_o (wr_stage_w),
        .sel_o      (sel_w),
        .commit_o   (commit_w)
    );

    ide_tim_commit #(
        .DW(DW), .NUM_DEV(NUM_DEV), .RST_TIM(RST_TIM), .RST_SETUP(RST_SETUP)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit_w),
        .rd_stage_i (rd_stage_w),
        .wr_stage_i (wr_stage_w),
        .sel_i      (sel_w),
        .rd_tim_o   (rd_timing),
        .wr_tim_o   (wr_timing),
        .setup_o    (setup_timing)
    );

    assign window_open = open_w;
    assign tf_sel      = ~open_w;

endmodule

// File: rtl/ide_cfgwin_chk.sv
// Port-level protocol checker for ide_cfgwin, attached by bind.
module ide_cfgwin_chk #(
    parameter int DW      = 8,
    parameter int NUM_DEV = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            io_addr,
    input logic                  io_rd,
    input logic                  io_wr,
    input logic                  io_wide,
    input logic [DW-1:0]         io_wdata,
    input logic                  bus_clk_25,
    input logic [DW-1:0]         cfg_rdata,
    input logic                  cfg_rvalid,
    input logic                  window_open,
    input logic [NUM_DEV*DW-1:0] rd_timing,
    input logic [NUM_DEV*DW-1:0] wr_timing,
    input logic [DW-1:0]         setup_timing
);

    // R2: opening only follows the unlock key write
    p_open_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_open) |-> $past(io_wr && !io_wide && io_addr == 3'd2 && io_wdata[7:0] == 8'h03));

    // R4: no read data while closed
    p_no_rdata_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !window_open |-> !cfg_rvalid);

    // R7: strap bit tracks the clock strap input
    p_strap_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && io_rd && io_addr == 3'd5) |-> (cfg_rdata[0] == bus_clk_25));

    // R8: committed outputs move only after an open-window commit write
    p_commit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_timing) || !$stable(wr_timing) || !$stable(setup_timing)) |->
        $past(window_open && io_wr && io_addr == 3'd3 && io_wdata[7:0] == 8'h85));

    // R10: closing only follows the relock key write
    p_close_on_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window_open) |-> $past(io_wr && !io_wide && io_addr == 3'd2 && io_wdata[7:0] == 8'h83));

endmodule

bind ide_cfgwin ide_cfgwin_chk #(.DW(DW), .NUM_DEV(NUM_DEV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .io_wide      (io_wide),
    .io_wdata     (io_wdata),
    .bus_clk_25   (bus_clk_25),
    .cfg_rdata    (cfg_rdata),
    .cfg_rvalid   (cfg_rvalid),
    .window_open  (window_open),
    .rd_timing    (rd_timing),
    .wr_timing    (wr_timing),
    .setup_timing (setup_timing)
);

// File: tb/ide_cfgwin_bench.sv
// Self-checking bench: a vector table for the main programming flow,
// then directed tests for knock breaks, locking, commit and reset.
module ide_cfgwin_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_wide = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        bus_clk_25 = 1'b1;
    logic [7:0]  cfg_rdata;
    logic        cfg_rvalid;
    logic        tf_sel;
    logic        window_open;
    logic [15:0] rd_timing;
    logic [15:0] wr_timing;
    logic [7:0]  setup_timing;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] cap_rdata;
    logic       cap_rvalid;
    logic       cap_tfsel;

    always #2 clk = ~clk;

    ide_cfgwin u_ide_cfgwin (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wide(io_wide), .io_wdata(io_wdata), .bus_clk_25(bus_clk_25),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .tf_sel(tf_sel),
        .window_open(window_open), .rd_timing(rd_timing), .wr_timing(wr_timing),
        .setup_timing(setup_timing)
    );

    // Vector fields: op[22:21] (1 read, 2 write), wide[20], addr[19:17],
    // data[16:9], check[8], expected read data[7:0]
    localparam logic [22:0] VEC [18] = '{
        {2'd1, 1'b1, 3'd1, 8'h00, 1'b0, 8'h00},
        {2'd1, 1'b1, 3'd1, 8'h00, 1'b0, 8'h00},
        {2'd2, 1'b0, 3'd2, 8'h03, 1'b0, 8'h00},
        {2'd1, 1'b0, 3'd5, 8'h00, 1'b1, 8'h01},
        {2'd2, 1'b0, 3'd6, 8'h21, 1'b0, 8'h00},
        {2'd2, 1'b0, 3'd0, 8'h46, 1'b0, 8'h00},
        {2'd2, 1'b0, 3'd1, 8'h32, 1'b0, 8'h00},
        {2'd1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h46},
        {2'd1, 1'b0, 3'd6, 8'h00, 1'b1, 8'h21},
        {2'd2, 1'b0, 3'd6, 8'h20, 1'b0, 8'h00},
        {2'd2, 1'b0, 3'd0, 8'h30, 1'b0, 8'h00},
        {2'd2, 1'b0, 3'd1, 8'h31, 1'b0, 8'h00},
        {2'd1, 1'b0, 3'd1, 8'h00, 1'b1, 8'h31},
        {2'd1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h00},
        {2'd2, 1'b0, 3'd5, 8'hFE, 1'b0, 8'h00},
        {2'd1, 1'b0, 3'd5, 8'h00, 1'b1, 8'h01},
        {2'd2, 1'b0, 3'd3, 8'h85, 1'b0, 8'h00},
        {2'd1, 1'b0, 3'd3, 8'h00, 1'b1, 8'h85}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at falling edge, capture combinational read, release
    task automatic acc(input int op, input logic wide, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wide  = wide;
        io_wdata = d;
        io_rd    = (op == 1);
        io_wr    = (op == 2);
        #1;
        cap_rdata  = cfg_rdata;
        cap_rvalid = cfg_rvalid;
        cap_tfsel  = tf_sel;
        @(negedge clk);
        io_rd = 1'b0;
        io_wr = 1'b0;
    endtask

    task automatic knock();
        acc(1, 1'b1, 3'd1, 8'h00);
        acc(1, 1'b1, 3'd1, 8'h00);
        acc(2, 1'b0, 3'd2, 8'h03);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 open", {31'd0, window_open}, 32'd0);
        check("R1 tf_sel", {31'd0, tf_sel}, 32'd1);
        check("R1 rd_timing", {16'd0, rd_timing}, 32'h5959);
        check("R1 wr_timing", {16'd0, wr_timing}, 32'h5959);
        check("R1 setup", {24'd0, setup_timing}, 32'h30);

        // Main flow from the vector table (R2, R5, R6, R7, R8)
        for (int i = 0; i < 18; i++) begin
            acc(int'(VEC[i][22:21]), VEC[i][20], VEC[i][19:17], VEC[i][16:9]);
            if (VEC[i][8]) begin
                check("R5 rvalid", {31'd0, cap_rvalid}, 32'd1);
                check("R5/R6/R7 rdata", {24'd0, cap_rdata}, {24'd0, VEC[i][7:0]});
            end
            if (i == 2) check("R2 open after knock", {31'd0, window_open}, 32'd1);
        end
        check("R8 rd_timing", {16'd0, rd_timing}, 32'h4630);
        check("R8 wr_timing", {16'd0, wr_timing}, 32'h3231);
        check("R8 setup", {24'd0, setup_timing}, 32'h20);

        // R9: staging without commit leaves outputs alone
        acc(2, 1'b0, 3'd0, 8'h10);
        acc(2, 1'b0, 3'd6, 8'h11);
        check("R9 rd_timing held", {16'd0, rd_timing}, 32'h4630);
        check("R9 setup held", {24'd0, setup_timing}, 32'h20);
        acc(2, 1'b0, 3'd6, 8'h10);
        // R8: non-commit control code
        acc(2, 1'b0, 3'd3, 8'h84);
        check("R8 no commit on 0x84", {16'd0, rd_timing}, 32'h4630);

        // R10: wrong relock forms keep window open
        acc(2, 1'b1, 3'd2, 8'h83);
        check("R10 wide relock ignored", {31'd0, window_open}, 32'd1);
        acc(2, 1'b0, 3'd2, 8'h82);
        check("R10 wrong relock ignored", {31'd0, window_open}, 32'd1);
        acc(2, 1'b0, 3'd2, 8'h83);
        check("R10 relock closes", {31'd0, window_open}, 32'd0);

        // R4: closed window gives no data and ignores commit writes
        acc(1, 1'b0, 3'd5, 8'h00);
        check("R4 rvalid locked", {31'd0, cap_rvalid}, 32'd0);
        check("R4 tf_sel locked", {31'd0, cap_tfsel}, 32'd1);
        acc(2, 1'b0, 3'd3, 8'h85);
        check("R4 locked commit ignored", {16'd0, rd_timing}, 32'h4630);

        // R3: broken knocks
        acc(1, 1'b1, 3'd1, 8'h00); acc(2, 1'b0, 3'd0, 8'h00);
        acc(1, 1'b1, 3'd1, 8'h00); acc(2, 1'b0, 3'd2, 8'h03);
        check("R3 write between reads", {31'd0, window_open}, 32'd0);
        acc(1, 1'b1, 3'd1, 8'h00); acc(1, 1'b1, 3'd1, 8'h00); acc(2, 1'b0, 3'd2, 8'h04);
        check("R3 wrong key", {31'd0, window_open}, 32'd0);
        acc(1, 1'b1, 3'd1, 8'h00); acc(1, 1'b1, 3'd1, 8'h00); acc(2, 1'b1, 3'd2, 8'h03);
        check("R3 wide key", {31'd0, window_open}, 32'd0);
        acc(1, 1'b0, 3'd1, 8'h00); acc(1, 1'b1, 3'd1, 8'h00); acc(2, 1'b0, 3'd2, 8'h03);
        check("R3 narrow read", {31'd0, window_open}, 32'd0);
        acc(1, 1'b1, 3'd1, 8'h00); acc(1, 1'b1, 3'd1, 8'h00);
        acc(1, 1'b1, 3'd1, 8'h00); acc(2, 1'b0, 3'd2, 8'h03);
        check("R3 third read", {31'd0, window_open}, 32'd0);

        // R2/R8: proper knock then commit the earlier staged drive-0 byte
        knock();
        check("R2 reopen", {31'd0, window_open}, 32'd1);
        acc(2, 1'b0, 3'd3, 8'h85);
        check("R8 commit staged", {16'd0, rd_timing}, 32'h4610);
        check("R8 setup masked", {24'd0, setup_timing}, 32'h10);

        // R7: strap follows 33 MHz setting
        bus_clk_25 = 1'b0;
        acc(1, 1'b0, 3'd5, 8'h00);
        check("R7 strap 33MHz", {24'd0, cap_rdata}, 32'h00);

        // R1: reset while open
        do_reset();
        check("R1 reset closes", {31'd0, window_open}, 32'd0);
        check("R1 reset timing", {16'd0, wr_timing}, 32'h5959);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule